// File: doc/BRIEF.md
# Shared Address/Data Bus Slave Decoder

This block sits on a parallel local bus whose lines carry a 28-bit address during the address phase and 32-bit data during the data phase. A strobe marks the address phase. On that strobe the block captures the address together with this chip's 3-bit hardwired identifier and an 8-bit page value. It then classifies the access as internal (register/RAM space), external (large memory space) or a miss.

The result is registered, so it is visible one clock after the address strobe. It stays unchanged until the next address strobe. During the data phase the read and write strobes are steered only to the selected space, and the bus data is passed through as write data. On a read hit the data from the selected space is returned. A miss selects nothing and returns nothing, and each missed address phase adds one to a saturating error count.

Top module: `mbd_slave`

## Requirements
- R1: After a synchronous active-low reset, and until the first address strobe, `int_sel`, `ext_sel`, `miss`, `bus_oe` are 0 and `err_count` is 0.
- R2: An address with bits 27..24 = 4'b0001 is an internal hit when `chip_id` = 3'b100.
- R3: An address with bits 27..26 = 2'b01 is an internal hit when `chip_id[2]` = 0 and bits 25..24 equal `chip_id[1:0]`.
- R4: On an internal hit, `int_addr` equals address bits 23..0. The page value has no influence on internal decode or on the internal address.
- R5: An address with bit 27 = 1 is an external hit when page bits 7..5 equal `chip_id`. In that case `ext_addr` = {page[4:0], address[26:0]}.
- R6: Any other combination is a miss: `miss` = 1, both selects 0, and `err_count` rises by one in the cycle after the address strobe.
- R7: Decode results appear one clock after the address strobe and stay unchanged until the next strobe, even if the bus lines, page or chip id change in between.
- R8: `int_wr`/`ext_wr` follow `wr_stb` only for the selected space. `wdata` carries the bus lines.
- R9: `int_rd`/`ext_rd` follow `rd_stb` only for the selected space. On a read hit `bus_oe` = 1 and `bus_out` is the selected space's read data. On a miss `bus_oe` = 0.
- R10: `err_count` saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_id | input | 3 | Hardwired chip identifier |
| page | input | 8 | Page value; top 3 bits select the chip for external accesses |
| ale | input | 1 | Address-phase strobe |
| rd_stb | input | 1 | Data-phase read strobe |
| wr_stb | input | 1 | Data-phase write strobe |
| bus_in | input | 32 | Shared address/data lines, inbound |
| bus_out | output | 32 | Read data driven back onto the bus |
| bus_oe | output | 1 | Read data drive enable |
| int_addr | output | 24 | Internal-space address |
| int_sel | output | 1 | Internal access decoded |
| int_wr | output | 1 | Internal write strobe |
| int_rd | output | 1 | Internal read strobe |
| int_rdata | input | 32 | Internal-space read data |
| ext_addr | output | 32 | External-space address |
| ext_sel | output | 1 | External access decoded |
| ext_wr | output | 1 | External write strobe |
| ext_rd | output | 1 | External read strobe |
| ext_rdata | input | 32 | External-space read data |
| wdata | output | 32 | Write data to the selected space |
| miss | output | 1 | Last address phase decoded to no space |
| err_count | output | ERR_W | Saturating count of missed address phases |

## Verification
The bench builds the block with a 4-bit error counter (`ERR_W` = 4). A sweep of all five chip ids, all sixteen values of bits 27..24 and three pages therefore produces enough misses to drive the counter into saturation within one run. The link-chip id and code stay at their defaults, so the one-code link rule and the four array-chip codes are both covered by the same sweep.

// File: rtl/mbd_pkg.sv
// Shared widths and the decode-space type for the shared-bus slave decoder.
// Assumes the address/code split leaves exactly ID_W-1 low code bits for the
// array-chip select, and that page low bits fill the external address.
package mbd_pkg;
    parameter int ADDR_W  = 28;
    parameter int DATA_W  = 32;
    parameter int ID_W    = 3;
    parameter int PAGE_W  = 8;
    parameter int INT_W   = 24;
    parameter int EXT_W   = 32;

    localparam int CODE_W    = ADDR_W - INT_W;
    localparam int ARR_SEL_W = ID_W - 1;
    localparam int PAGE_LO_W = EXT_W - (ADDR_W - 1);

    typedef enum logic [1:0] {
        SPACE_NONE = 2'd0,
        SPACE_INT  = 2'd1,
        SPACE_EXT  = 2'd2
    } space_e;
endpackage

// File: rtl/mbd_space_decode.sv
// Combinational classifier: given a captured address, chip id and page,
// decides internal / external / none and forms both target addresses.
// Assumes CODE_W - 2 == ARR_SEL_W (array-chip codes are 01 followed by id bits).
module mbd_space_decode
    import mbd_pkg::*;
#(
    parameter logic [ID_W-1:0]   LINK_ID   = 3'b100,
    parameter logic [CODE_W-1:0] LINK_CODE = 4'b0001
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [PAGE_W-1:0] page,
    output space_e            space,
    output logic [INT_W-1:0]  int_addr,
    output logic [EXT_W-1:0]  ext_addr
);
    logic [CODE_W-1:0] code;
    logic              ext_space;
    logic              link_hit;
    logic              array_hit;
    logic              ext_hit;

    // Split the address into space bit and chip code field.
    always_comb begin
        code      = addr[ADDR_W-1 -: CODE_W];
        ext_space = addr[ADDR_W-1];
    end

    // Evaluate the three match rules.
    always_comb begin
        link_hit  = (chip_id == LINK_ID) && (code == LINK_CODE);
        array_hit = !chip_id[ID_W-1]
                    && (code[CODE_W-1 -: 2] == 2'b01)
                    && (code[ARR_SEL_W-1:0] == chip_id[ARR_SEL_W-1:0]);
        ext_hit   = ext_space && (page[PAGE_W-1 -: ID_W] == chip_id);
    end

    // Pick the space; internal rules only apply with the space bit clear.
    always_comb begin
        if (ext_hit)
            space = SPACE_EXT;
        else if (!ext_space && (link_hit || array_hit))
            space = SPACE_INT;
        else
            space = SPACE_NONE;
    end

    // Form the target addresses.
    always_comb begin
        int_addr = addr[INT_W-1:0];
        ext_addr = {page[PAGE_LO_W-1:0], addr[ADDR_W-2:0]};
    end
endmodule

// File: rtl/mbd_addr_latch.sv
// Holds the decode result of the most recent address phase.
// Loads on ale; otherwise holds. Miss is only reported once an address
// phase has been seen since reset.
module mbd_addr_latch
    import mbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale,
    input  space_e           space_d,
    input  logic [INT_W-1:0] int_addr_d,
    input  logic [EXT_W-1:0] ext_addr_d,
    output space_e           space_q,
    output logic [INT_W-1:0] int_addr_q,
    output logic [EXT_W-1:0] ext_addr_q,
    output logic             miss_q
);
    logic seen_q;

    // Capture decode on the address strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q    <= SPACE_NONE;
            int_addr_q <= '0;
            ext_addr_q <= '0;
            seen_q     <= 1'b0;
        end else if (ale) begin
            space_q    <= space_d;
            int_addr_q <= int_addr_d;
            ext_addr_q <= ext_addr_d;
            seen_q     <= 1'b1;
        end
    end

    // Miss flag: an address phase happened and matched nothing.
    always_comb miss_q = seen_q && (space_q == SPACE_NONE);

    // R7
    hold_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> ($stable(space_q) && $stable(int_addr_q) && $stable(ext_addr_q)));
endmodule

// File: rtl/mbd_err_counter.sv
// Saturating counter of missed address phases.
// Assumes inc is a single-cycle pulse per address phase.
module mbd_err_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = '1;

    // Count up on each miss, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && (count != MAX))
            count <= count + 1'b1;
    end

    // R6
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (count != MAX)) |=> (count == $past(count) + 1'b1));

    // R10
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAX) |=> (count == MAX));
endmodule

// File: rtl/mbd_slave.sv
// Shared address/data bus slave: captures the address phase, classifies it
// against this chip's id and the page value, and steers data-phase strobes
// and read data to the selected space. Assumes ale and data strobes never
// coincide and that chip_id is static in normal use.
module mbd_slave
    import mbd_pkg::*;
#(
    parameter int                ERR_W     = 8,
    parameter logic [ID_W-1:0]   LINK_ID   = 3'b100,
    parameter logic [CODE_W-1:0] LINK_CODE = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [PAGE_W-1:0] page,
    input  logic              ale,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [INT_W-1:0]  int_addr,
    output logic              int_sel,
    output logic              int_wr,
    output logic              int_rd,
    input  logic [DATA_W-1:0] int_rdata,
    output logic [EXT_W-1:0]  ext_addr,
    output logic              ext_sel,
    output logic              ext_wr,
    output logic              ext_rd,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] wdata,
    output logic              miss,
    output logic [ERR_W-1:0]  err_count
);
    space_e           space_d;
    space_e           space_q;
    logic [INT_W-1:0] int_addr_d;
    logic [EXT_W-1:0] ext_addr_d;
    logic             err_inc;

    mbd_space_decode #(
        .LINK_ID   (LINK_ID),
        .LINK_CODE (LINK_CODE)
    ) u_decode (
        .addr     (bus_in[ADDR_W-1:0]),
        .chip_id  (chip_id),
        .page     (page),
        .space    (space_d),
        .int_addr (int_addr_d),
        .ext_addr (ext_addr_d)
    );

    mbd_addr_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ale        (ale),
        .space_d    (space_d),
        .int_addr_d (int_addr_d),
        .ext_addr_d (ext_addr_d),
        .space_q    (space_q),
        .int_addr_q (int_addr),
        .ext_addr_q (ext_addr),
        .miss_q     (miss)
    );

    // One error per address phase that matches no space.
    always_comb err_inc = ale && (space_d == SPACE_NONE);

    mbd_err_counter #(
        .W (ERR_W)
    ) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_inc),
        .count (err_count)
    );

    // Space selects from the held decode.
    always_comb begin
        int_sel = (space_q == SPACE_INT);
        ext_sel = (space_q == SPACE_EXT);
    end

    // Steer data-phase strobes to the selected space only.
    always_comb begin
        int_wr = wr_stb && int_sel;
        ext_wr = wr_stb && ext_sel;
        int_rd = rd_stb && int_sel;
        ext_rd = rd_stb && ext_sel;
        wdata  = bus_in;
    end

    // Return read data from the selected space; drive nothing on a miss.
    always_comb begin
        bus_oe  = int_rd || ext_rd;
        bus_out = '0;
        if (int_rd)
            bus_out = int_rdata;
        else if (ext_rd)
            bus_out = ext_rdata;
    end

    // R6
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (!int_sel && !ext_sel));

    // R8
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_wr, ext_wr}) && ((int_wr || ext_wr) -> wr_stb));

    // R9
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (rd_stb && !miss));
endmodule

// File: tb/mbd_slave_tb.sv
module mbd_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ERR_W      = 4;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] INT_RD = 32'h1A2B_3C4D;
    localparam logic [31:0] EXT_RD = 32'hE5F6_0718;

    // {chip id, bits 27..24, page, exp_int, exp_ext}
    localparam logic [16:0] VEC [12] = '{
        {3'd4, 4'h1, 8'h00, 2'b10},
        {3'd4, 4'h4, 8'h00, 2'b00},
        {3'd0, 4'h4, 8'hFF, 2'b10},
        {3'd1, 4'h5, 8'h00, 2'b10},
        {3'd2, 4'h6, 8'h00, 2'b10},
        {3'd3, 4'h7, 8'h7F, 2'b10},
        {3'd3, 4'h6, 8'h00, 2'b00},
        {3'd0, 4'h1, 8'h00, 2'b00},
        {3'd4, 4'h8, 8'h80, 2'b01},
        {3'd2, 4'h9, 8'h5F, 2'b01},
        {3'd2, 4'hF, 8'h60, 2'b00},
        {3'd1, 4'h0, 8'h20, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  chip_id = 3'd0;
    logic [7:0]  page = 8'd0;
    logic        ale = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [31:0] bus_in = 32'd0;
    logic [31:0] bus_out;
    logic        bus_oe;
    logic [23:0] int_addr;
    logic        int_sel, int_wr, int_rd;
    logic [31:0] ext_addr;
    logic        ext_sel, ext_wr, ext_rd;
    logic [31:0] wdata;
    logic        miss;
    logic [ERR_W-1:0] err_count;

    int checks = 0;
    int fails  = 0;
    int err_exp = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbd_slave #(.ERR_W(ERR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .page(page),
        .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe),
        .int_addr(int_addr), .int_sel(int_sel), .int_wr(int_wr), .int_rd(int_rd),
        .int_rdata(INT_RD),
        .ext_addr(ext_addr), .ext_sel(ext_sel), .ext_wr(ext_wr), .ext_rd(ext_rd),
        .ext_rdata(EXT_RD),
        .wdata(wdata), .miss(miss), .err_count(err_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected space from the requirements: 0 none, 1 internal, 2 external.
    function automatic int ref_space(input logic [2:0] id, input logic [27:0] a,
                                     input logic [7:0] pg);
        if (a[27]) return (pg[7:5] == id) ? 2 : 0;
        if (id == 3'd4 && a[27:24] == 4'b0001) return 1;
        if (!id[2] && a[27:26] == 2'b01 && a[25:24] == id[1:0]) return 1;
        return 0;
    endfunction

    task automatic access(input logic [2:0] id, input logic [7:0] pg,
                          input logic [27:0] a, input int exp_sp);
        logic [31:0] d;
        d = 32'hD00D_0000 ^ {4'h0, a};
        @(negedge clk);
        chip_id = id; page = pg; bus_in = {4'h0, a}; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0; bus_in = d; page = ~pg; chip_id = id ^ 3'b101;   // R7 held
        if (exp_sp == 0 && err_exp < (1 << ERR_W) - 1) err_exp++;
        chk("R2/R3 int_sel", 32'(int_sel), 32'(exp_sp == 1));
        chk("R5 ext_sel", 32'(ext_sel), 32'(exp_sp == 2));
        chk("R6 miss", 32'(miss), 32'(exp_sp == 0));
        chk("R6 err_count", 32'(err_count), 32'(err_exp));
        if (exp_sp == 1) chk("R4 int_addr", 32'(int_addr), 32'(a[23:0]));
        if (exp_sp == 2) chk("R5 ext_addr", ext_addr, {pg[4:0], a[26:0]});
        wr_stb = 1'b1; #1;
        chk("R8 int_wr", 32'(int_wr), 32'(exp_sp == 1));
        chk("R8 ext_wr", 32'(ext_wr), 32'(exp_sp == 2));
        chk("R8 wdata", wdata, d);
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b1; #1;
        chk("R9 int_rd", 32'(int_rd), 32'(exp_sp == 1));
        chk("R9 ext_rd", 32'(ext_rd), 32'(exp_sp == 2));
        chk("R9 bus_oe", 32'(bus_oe), 32'(exp_sp != 0));
        if (exp_sp == 1) chk("R9 bus_out", bus_out, INT_RD);
        if (exp_sp == 2) chk("R9 bus_out", bus_out, EXT_RD);
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R7 held int_sel", 32'(int_sel), 32'(exp_sp == 1));
    endtask

    task automatic reset_and_check();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; rd_stb = 1'b1; #1;
        err_exp = 0;
        chk("R1 int_sel", 32'(int_sel), 32'd0);
        chk("R1 ext_sel", 32'(ext_sel), 32'd0);
        chk("R1 miss", 32'(miss), 32'd0);
        chk("R1 bus_oe", 32'(bus_oe), 32'd0);
        chk("R1 err_count", 32'(err_count), 32'd0);
        @(negedge clk); rd_stb = 1'b0;
    endtask

    initial begin
        reset_and_check();
        // Table of directed vectors.
        for (int i = 0; i < 12; i++) begin
            logic [16:0] v;
            int sp;
            v = VEC[i];
            sp = v[1] ? 1 : (v[0] ? 2 : 0);
            access(v[16:14], v[9:2], {v[13:10], 24'hA5C300 + 24'(i)}, sp);
        end
        // Sweep: every chip id, every code, three pages (R2 R3 R4 R5 R6 R10).
        for (int id = 0; id < 5; id++) begin
            for (int c = 0; c < 16; c++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [7:0]  pg;
                    logic [27:0] a;
                    pg = (p == 0) ? {3'(id), 5'h15} : (p == 1) ? {3'(id + 1), 5'h0A} : 8'hE0;
                    a  = {4'(c), 24'h3C5A00 + 24'(id * 48 + c * 3 + p)};
                    access(3'(id), pg, a, ref_space(3'(id), a, pg));
                end
            end
        end
        // R10: counter must be pinned at its top value after the sweep.
        chk("R10 saturated", 32'(err_count), 32'((1 << ERR_W) - 1));
        access(3'd1, 8'h00, 28'h0000123, 0);
        chk("R10 still saturated", 32'(err_count), 32'((1 << ERR_W) - 1));
        // R1: reset clears everything after activity.
        reset_and_check();
        access(3'd4, 8'hFF, 28'h1FFFFFF, 1);
        access(3'd7, 8'hFF, 28'h8000001, 2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d cycles expected=fewer", WATCHDOG);
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end
endmodule